// File: doc/BRIEF.md
# Flash Toggle Status Bit Generator

This block sits on the device side of a sector-erasable flash memory model. While an internal program or erase operation is running, it returns a status byte on reads instead of array contents. The host polls the status byte and compares two back-to-back reads. Bit 6 inverts on every status read while an operation makes progress. Bit 2 inverts only when the read falls in a sector marked for erasure. Bit 5 reports that an operation has run too long.

Bit 2 alone shows which sectors take part in an erase, but it cannot tell an active erase from a suspended one. Bit 6 alone tells those two states apart. The host reads both bits together to learn the sector and the mode.

The command decoder drives the operation-state inputs once it has seen the final write of a command sequence. It also pulses a program-start strobe with the target sector, so a program aimed at a protected sector can be answered with a short toggling window. A reset command ends any status output and returns the block to array reads.

Top module: `flash_toggle_status`

## Requirements
- R1: The data output is registered and changes on the clock edge that samples `rd_stb`. A status byte carries the operation toggle in bit 6, the timeout flag in bit 5 and the sector toggle in bit 2. Bits 7, 4, 3, 1 and 0 of a status byte are 0.
- R2: While `pgm_busy` is high, or `ers_busy` is high with `ers_susp` low, every read returns status and bit 6 has the opposite value from the previous status read. `busy_o` is high.
- R3: While `susp_pgm_busy` is high, bit 6 inverts on each read, including reads of sectors that are not marked for erasure.
- R4: A `pgm_start` pulse whose `pgm_sector` is set in `prot_mask` makes `busy_o` high and bit 6 toggle for exactly PROT_WIN_CYCLES cycles, starting the cycle after the pulse. Reads return array data after that window. A pulse to an unprotected sector starts no window.
- R5: While `ers_susp` is high and no program is running, bit 6 keeps the same value across status reads.
- R6: While an erase is present (`ers_busy` or `ers_susp` high), bit 2 inverts on each read of a sector whose bit is set in `ers_sel`. It keeps its value on status reads of other sectors. It behaves the same in the active and the suspended state.
- R7: While `ers_susp` is high and no program is running, a read of a sector whose `ers_sel` bit is clear returns `array_data`.
- R8: Bit 5 rises after TIMEOUT_CYCLES consecutive cycles of a running operation. It stays high until `reset_cmd`, and bit 6 keeps toggling while it is high, even after the busy inputs drop.
- R9: A `reset_cmd` pulse clears bit 5 and makes `busy_o` low on the next cycle. Reads then return `array_data` until all operation-state inputs have been low for at least one cycle.
- R10: After reset `dout` is 0 and `busy_o` is low. With no operation, reads return `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_sector | input | SECT_W | Sector field of the read address |
| array_data | input | 8 | Array contents for the current read |
| pgm_busy | input | 1 | Program operation running |
| ers_busy | input | 1 | Erase operation present |
| ers_susp | input | 1 | Erase is suspended |
| susp_pgm_busy | input | 1 | Program running inside erase suspend |
| pgm_start | input | 1 | Program command accepted (after final write strobe) |
| pgm_sector | input | SECT_W | Target sector of the program command |
| ers_sel | input | NUM_SECTORS | Sectors marked for erasure |
| prot_mask | input | NUM_SECTORS | Protected sectors |
| reset_cmd | input | 1 | Reset command pulse |
| dout | output | 8 | Read data: status byte or array data |
| busy_o | output | 1 | High while in status mode, low in array mode |

## Verification
The pair-compare reads run under program, active erase, erase suspend and program inside suspend. Each mode is tried on a sector marked for erasure and on one that is not, so that a bit 6 flip is kept apart from a bit 2 flip, and suspend is kept apart from active erase. The protected-sector window is checked on its last busy cycle and its first idle cycle, and an unprotected start is checked to produce no window. The timeout is checked before and after its limit, with the busy inputs dropped, and against a reset command given while an operation is still asserted.

// File: rtl/fts_pkg.sv
// Package: shared bit positions of the toggle status byte.
// Assumes an 8-bit data bus.
package fts_pkg;
    localparam int DATA_W = 8;
    localparam int BIT_OP_TOG  = 6;
    localparam int BIT_TMO     = 5;
    localparam int BIT_SEC_TOG = 2;
endpackage

// File: rtl/fts_sector_lookup.sv
// Module: looks up one sector's bit in a per-sector mask.
// Assumes sector numbers at or above NUM_SECTORS map to no sector.
module fts_sector_lookup #(
    parameter int NUM_SECTORS = 8,
    localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic [SECT_W-1:0]      sector,
    input  logic [NUM_SECTORS-1:0] mask,
    output logic                   hit
);
    logic [NUM_SECTORS-1:0] match;

    genvar s;
    generate
        for (s = 0; s < NUM_SECTORS; s++) begin : g_sec
            assign match[s] = mask[s] && (sector == SECT_W'(s));
        end
    endgenerate

    assign hit = |match;
endmodule

// File: rtl/fts_prot_window.sv
// Module: counts down the toggling window started by a program aimed at a
// protected sector. Assumes PROT_WIN_CYCLES >= 1.
module fts_prot_window #(
    parameter int PROT_WIN_CYCLES = 125,
    localparam int PW_W = $clog2(PROT_WIN_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    output logic active
);
    logic [PW_W-1:0] cnt;

    // Load on start, count down to zero, clear on reset command.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (start) cnt <= PW_W'(PROT_WIN_CYCLES);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/fts_timeout.sv
// Module: raises a sticky flag after TIMEOUT_CYCLES consecutive run cycles.
// Assumes the flag is cleared only by reset or the clear input.
module fts_timeout #(
    parameter int TIMEOUT_CYCLES = 1000,
    localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic flag
);
    logic [TO_W-1:0] cnt;

    // Count consecutive run cycles; restart when the run stops.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) cnt <= '0;
        else if (cnt != TO_W'(TIMEOUT_CYCLES - 1)) cnt <= cnt + 1'b1;
    end

    // Set the flag when the limit is hit; hold it until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) flag <= 1'b0;
        else if (run && cnt == TO_W'(TIMEOUT_CYCLES - 1)) flag <= 1'b1;
    end
endmodule

// File: rtl/fts_toggle_core.sv
// Module: holds the two toggle bits and the registered read data.
// Assumes the caller decides per read whether status or array data is due.
module fts_toggle_core
    import fts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              status_rd,
    input  logic              tog_op,
    input  logic              tog_sec,
    input  logic              tmo,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dout
);
    logic op_bit, sec_bit;
    logic op_nxt, sec_nxt;
    logic [DATA_W-1:0] sts;

    // Next toggle values for a status read.
    always_comb begin
        op_nxt  = op_bit ^ tog_op;
        sec_nxt = sec_bit ^ tog_sec;
        sts = '0;
        sts[BIT_OP_TOG]  = op_nxt;
        sts[BIT_TMO]     = tmo;
        sts[BIT_SEC_TOG] = sec_nxt;
    end

    // Update toggle bits and capture output data on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_bit  <= 1'b0;
            sec_bit <= 1'b0;
            dout    <= '0;
        end else if (rd_stb) begin
            if (status_rd) begin
                op_bit  <= op_nxt;
                sec_bit <= sec_nxt;
                dout    <= sts;
            end else begin
                dout <= array_data;
            end
        end
    end
endmodule

// File: rtl/flash_toggle_status.sv
// Module: top of the toggle status generator. It decides per read whether
// status or array data is returned and which toggle bits flip.
// Assumes the operation-state inputs come from a command decoder that raises
// them after the final write strobe of a command sequence.
module flash_toggle_status
    import fts_pkg::*;
#(
    parameter int NUM_SECTORS     = 8,
    parameter int PROT_WIN_CYCLES = 125,
    parameter int TIMEOUT_CYCLES  = 1000,
    localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_stb,
    input  logic [SECT_W-1:0]      rd_sector,
    input  logic [7:0]             array_data,
    input  logic                   pgm_busy,
    input  logic                   ers_busy,
    input  logic                   ers_susp,
    input  logic                   susp_pgm_busy,
    input  logic                   pgm_start,
    input  logic [SECT_W-1:0]      pgm_sector,
    input  logic [NUM_SECTORS-1:0] ers_sel,
    input  logic [NUM_SECTORS-1:0] prot_mask,
    input  logic                   reset_cmd,
    output logic [7:0]             dout,
    output logic                   busy_o
);
    logic rd_sel_hit, pgm_prot_hit;
    logic prot_win, to_flag, abort;
    logic any_op, ers_present, ers_act, run, tog6, tog2, status_rd;

    fts_sector_lookup #(.NUM_SECTORS(NUM_SECTORS)) u_rd_lookup (
        .sector(rd_sector), .mask(ers_sel), .hit(rd_sel_hit));

    fts_sector_lookup #(.NUM_SECTORS(NUM_SECTORS)) u_pgm_lookup (
        .sector(pgm_sector), .mask(prot_mask), .hit(pgm_prot_hit));

    // Operation summary terms.
    always_comb begin
        any_op      = pgm_busy | ers_busy | ers_susp | susp_pgm_busy;
        ers_present = ers_busy | ers_susp;
        ers_act     = ers_busy & ~ers_susp;
        run         = ~abort & (pgm_busy | ers_act | susp_pgm_busy);
        tog6        = ~abort & (pgm_busy | ers_act | susp_pgm_busy | prot_win | to_flag);
        status_rd   = tog6 | (~abort & ers_susp & rd_sel_hit);
        tog2        = status_rd & ers_present & rd_sel_hit;
        busy_o      = tog6 | (~abort & ers_susp);
    end

    // Abort latch: set by reset command, released once the decoder goes idle.
    always_ff @(posedge clk) begin
        if (!rst_n) abort <= 1'b0;
        else if (reset_cmd) abort <= 1'b1;
        else if (!any_op) abort <= 1'b0;
    end

    fts_prot_window #(.PROT_WIN_CYCLES(PROT_WIN_CYCLES)) u_prot (
        .clk(clk), .rst_n(rst_n), .start(pgm_start & pgm_prot_hit),
        .clear(reset_cmd), .active(prot_win));

    fts_timeout #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmo (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(reset_cmd), .flag(to_flag));

    fts_toggle_core u_core (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .status_rd(status_rd),
        .tog_op(tog6), .tog_sec(tog2), .tmo(to_flag),
        .array_data(array_data), .dout(dout));
endmodule

// File: rtl/fts_checker.sv
// Module: assertion checker bound to the top of the toggle status generator.
// Assumes it sees internal decision signals through the bind connections.
module fts_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       status_rd,
    input logic       tog6,
    input logic [7:0] dout,
    input logic [7:0] array_data,
    input logic       reset_cmd,
    input logic       busy_o,
    input logic       prot_win,
    input logic       pgm_start,
    input logic       to_flag
);
    // Back-to-back toggling status reads flip bit 6.
    assert_b6_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && status_rd && tog6 && $past(rd_stb && status_rd && tog6))
        |=> (dout[6] != $past(dout[6])));

    // Back-to-back non-toggling status reads hold bit 6.
    assert_b6_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && status_rd && !tog6 && $past(rd_stb && status_rd && !tog6))
        |=> (dout[6] == $past(dout[6])));

    // Array reads pass the array data through.
    assert_array_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !status_rd) |=> (dout == $past(array_data)));

    // A protected window only opens after a program start.
    assert_prot_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_win) |-> $past(pgm_start));

    // Timeout flag is sticky until reset command.
    assert_tmo_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !reset_cmd) |=> to_flag);

    // Reset command forces array mode and clears the timeout.
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> (!busy_o && !to_flag));
endmodule

bind flash_toggle_status fts_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .status_rd(status_rd),
    .tog6(tog6), .dout(dout), .array_data(array_data), .reset_cmd(reset_cmd),
    .busy_o(busy_o), .prot_win(prot_win), .pgm_start(pgm_start),
    .to_flag(to_flag));

// File: tb/flash_toggle_status_bench.sv
// Directed bench for the toggle status generator.
module flash_toggle_status_bench;
    localparam int NS = 8;
    localparam int SW = 3;
    localparam int PW = 20;
    localparam int TO = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_stb = 1'b0;
    logic [SW-1:0] rd_sector = '0;
    logic [7:0] array_data = 8'h00;
    logic pgm_busy = 1'b0, ers_busy = 1'b0, ers_susp = 1'b0, susp_pgm_busy = 1'b0;
    logic pgm_start = 1'b0;
    logic [SW-1:0] pgm_sector = '0;
    logic [NS-1:0] ers_sel = '0;
    logic [NS-1:0] prot_mask = '0;
    logic reset_cmd = 1'b0;
    logic [7:0] dout;
    logic busy_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    flash_toggle_status #(.NUM_SECTORS(NS), .PROT_WIN_CYCLES(PW), .TIMEOUT_CYCLES(TO))
    u_flash_toggle_status (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_sector(rd_sector),
        .array_data(array_data), .pgm_busy(pgm_busy), .ers_busy(ers_busy),
        .ers_susp(ers_susp), .susp_pgm_busy(susp_pgm_busy), .pgm_start(pgm_start),
        .pgm_sector(pgm_sector), .ers_sel(ers_sel), .prot_mask(prot_mask),
        .reset_cmd(reset_cmd), .dout(dout), .busy_o(busy_o));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One read: strobe for one edge, sample at the following negedge.
    task automatic rd(input int s, output logic [7:0] d);
        rd_sector = SW'(s);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        d = dout;
    endtask

    task automatic t_reset();
        check(dout == 8'h00, "R10 reset dout", dout, 0);
        check(busy_o == 1'b0, "R10 reset busy", busy_o, 0);
    endtask

    task automatic t_idle();
        logic [7:0] d;
        array_data = 8'hA5;
        rd(1, d);
        check(d == 8'hA5, "R10 idle array read", d, 8'hA5);
    endtask

    task automatic t_program();
        logic [7:0] a, b, c;
        pgm_busy = 1'b1;
        tick(1);
        check(busy_o == 1'b1, "R2 busy during program", busy_o, 1);
        rd(4, a); rd(4, b); rd(5, c);
        check(b[6] != a[6], "R2 bit6 flip 1", b[6], ~a[6]);
        check(c[6] != b[6], "R2 bit6 flip 2", c[6], ~b[6]);
        check(c[2] == b[2], "R6 bit2 hold without erase", c[2], b[2]);
        check((c & 8'h9B) == 8'h00, "R1 unused status bits", c & 8'h9B, 0);
        pgm_busy = 1'b0;
        array_data = 8'h5A;
        tick(1);
        rd(4, a);
        check(a == 8'h5A, "R2 array after program", a, 8'h5A);
    endtask

    task automatic t_erase();
        logic [7:0] a, b;
        ers_sel = 8'b0000_0101;
        ers_busy = 1'b1;
        tick(1);
        rd(0, a); rd(0, b);
        check(b[6] != a[6], "R2 erase bit6 flip", b[6], ~a[6]);
        check(b[2] != a[2], "R6 erase bit2 flip selected", b[2], ~a[2]);
        rd(1, a); rd(1, b);
        check(b[6] != a[6], "R2 erase bit6 flip unselected", b[6], ~a[6]);
        check(b[2] == a[2], "R6 bit2 hold unselected", b[2], a[2]);
        ers_susp = 1'b1;
        tick(1);
        rd(2, a); rd(2, b);
        check(b[6] == a[6], "R5 bit6 steady in suspend", b[6], a[6]);
        check(b[2] != a[2], "R6 bit2 flip in suspend", b[2], ~a[2]);
        check(busy_o == 1'b1, "R5 busy in suspend", busy_o, 1);
        array_data = 8'h3C;
        rd(1, a);
        check(a == 8'h3C, "R7 array read unselected in suspend", a, 8'h3C);
        susp_pgm_busy = 1'b1;
        tick(1);
        rd(1, a); rd(1, b);
        check(b[6] != a[6], "R3 bit6 flip suspend program", b[6], ~a[6]);
        susp_pgm_busy = 1'b0;
        ers_susp = 1'b0;
        ers_busy = 1'b0;
        ers_sel = '0;
        tick(1);
        check(busy_o == 1'b0, "R2 idle after erase", busy_o, 0);
    endtask

    task automatic t_protected();
        logic [7:0] a, b;
        prot_mask = 8'b0000_1000;
        pgm_sector = 3'd3;
        pgm_start = 1'b1;
        tick(1);
        pgm_start = 1'b0;
        check(busy_o == 1'b1, "R4 window open", busy_o, 1);
        rd(6, a); rd(6, b);
        check(b[6] != a[6], "R4 bit6 flip in window", b[6], ~a[6]);
        tick(PW - 3);
        check(busy_o == 1'b1, "R4 last window cycle", busy_o, 1);
        tick(1);
        check(busy_o == 1'b0, "R4 window closed", busy_o, 0);
        array_data = 8'h77;
        rd(3, a);
        check(a == 8'h77, "R4 array after window", a, 8'h77);
        pgm_sector = 3'd2;
        pgm_start = 1'b1;
        tick(1);
        pgm_start = 1'b0;
        check(busy_o == 1'b0, "R4 unprotected no window", busy_o, 0);
    endtask

    task automatic t_timeout();
        logic [7:0] a, b;
        pgm_busy = 1'b1;
        tick(30);
        rd(0, a);
        check(a[5] == 1'b0, "R8 no timeout early", a[5], 0);
        tick(40);
        rd(0, a);
        check(a[5] == 1'b1, "R8 timeout set", a[5], 1);
        pgm_busy = 1'b0;
        tick(1);
        check(busy_o == 1'b1, "R8 busy held by timeout", busy_o, 1);
        rd(0, a); rd(0, b);
        check(b[6] != a[6], "R8 bit6 keeps toggling", b[6], ~a[6]);
        check(b[5] == 1'b1, "R8 timeout sticky", b[5], 1);
        reset_cmd = 1'b1;
        tick(1);
        reset_cmd = 1'b0;
        check(busy_o == 1'b0, "R9 reset clears busy", busy_o, 0);
        array_data = 8'h12;
        rd(0, a);
        check(a == 8'h12, "R9 array after reset", a, 8'h12);
        pgm_busy = 1'b1;
        tick(2);
        reset_cmd = 1'b1;
        tick(1);
        reset_cmd = 1'b0;
        array_data = 8'h34;
        rd(0, a);
        check(a == 8'h34, "R9 array while op held", a, 8'h34);
        check(busy_o == 1'b0, "R9 abort while op held", busy_o, 0);
        pgm_busy = 1'b0;
        tick(2);
        pgm_busy = 1'b1;
        tick(1);
        check(busy_o == 1'b1, "R9 abort released", busy_o, 1);
        rd(0, a);
        check(a[5] == 1'b0, "R9 bit5 cleared", a[5], 0);
        pgm_busy = 1'b0;
        tick(1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_idle();
        t_program();
        t_erase();
        t_protected();
        t_timeout();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule